// File: doc/BRIEF.md
# Hit Edge-Trigger and Transfer Controller

This controller watches a single merged hit line and drives the timing around it. A rising hit raises a leading-edge trigger, which also tells the hit merger to stop collecting pileup information for the hit in flight. A falling hit raises a trailing-edge trigger, which also blocks the merger's hit output. The falling edge also posts a transfer request. When the downstream side reports ready, the controller answers with a one-cycle transfer strobe that moves the captured time data into synchronization registers. On the edge after that strobe, both triggers drop and a one-cycle pulse clears the merger's pileup state.

All inputs are sampled on the rising clock edge and every output comes from a register. Every edge therefore shows up with a fixed one-cycle latency. A rising edge that arrives while a hit is still being handled is ignored: it raises no second leading trigger and leads to no second transfer. If downstream is not ready, the request is held and the triggers stay high until the transfer takes place.

Top module: `hit_trigger_ctrl`

## Requirements
- R1: While `rst` is sampled high at a clock edge, every output is low after that edge, and any pending request is dropped.
- R2: When an edge samples `hit` high and the previous edge sampled it low, and `lead_trig` is low, `lead_trig` and `blk_pileup` go high after that edge and stay high until the transfer clears them.
- R3: When an edge samples `hit` low, the previous edge sampled it high, `lead_trig` is high and `trail_trig` is low, `trail_trig` and `blk_hit` go high after that edge.
- R4: With `daq_ready` high, `xfer_load` is high for exactly one cycle, beginning on the edge after `trail_trig` rises. Each accepted hit produces exactly one strobe.
- R5: On the edge after `xfer_load` is high, `lead_trig`, `trail_trig`, `blk_hit` and `blk_pileup` all go low. With `daq_ready` high, `trail_trig` is therefore high for exactly 2 cycles.
- R6: While `daq_ready` is sampled low, `xfer_load` stays low and both triggers stay high. The strobe is issued after the first edge that samples `daq_ready` high while the request is pending.
- R7: `pileup_clr` is high for exactly one cycle, beginning on the edge after the `xfer_load` cycle.
- R8: A rising `hit` while `lead_trig` is high (including the strobe cycle) is ignored. A hit that began this way produces no leading trigger, no trailing trigger and no strobe.

Top module is the only entry point; triggers are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hit | input | 1 | Merged hit line from the hit merger |
| daq_ready | input | 1 | Downstream ready to accept a transfer |
| lead_trig | output | 1 | Leading-edge trigger for time-stamp capture |
| trail_trig | output | 1 | Trailing-edge trigger for time-stamp capture |
| blk_hit | output | 1 | Blocks the merger's hit output |
| blk_pileup | output | 1 | Ends pileup collection for the current hit |
| xfer_load | output | 1 | One-cycle strobe moving captured data to sync registers |
| pileup_clr | output | 1 | One-cycle pulse clearing the merger's pileup state |

## Verification
The transfer strobe that clears the triggers can fall in the same cycle as a fresh rising edge on `hit`. The bench provokes this by raising `hit` while a request is stalled by a low `daq_ready`, and holding it through the strobe and the clear. The clear must win: after it, no leading trigger returns while the late hit stays high, and its later falling edge raises no trailing trigger and no second strobe.

// File: rtl/hit_trigger_pkg.sv
package hit_trigger_pkg;

    typedef struct packed {
        logic lead;
        logic trail;
    } trig_state_t;

    typedef struct packed {
        logic req;
        logic load;
        logic clr;
    } xfer_state_t;

endpackage

// File: rtl/hit_edge_detect.sv
module hit_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = hit;
        rise   = hit & ~prev_q;
        fall   = ~hit & prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/hit_trig_state.sv
module hit_trig_state
    import hit_trigger_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic fall,
    input  logic load,
    output logic lead,
    output logic trail,
    output logic req_set
);
    trig_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        req_set = fall & st_q.lead & ~st_q.trail & ~load;
        if (load) begin
            st_d.lead  = 1'b0;
            st_d.trail = 1'b0;
        end else begin
            if (rise && !st_q.lead) st_d.lead  = 1'b1;
            if (req_set)            st_d.trail = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lead  = st_q.lead;
    assign trail = st_q.trail;
endmodule

// File: rtl/hit_xfer_seq.sv
module hit_xfer_seq
    import hit_trigger_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_set,
    input  logic daq_ready,
    output logic load,
    output logic clr
);
    xfer_state_t st_d, st_q;
    logic        grant;

    always_comb begin
        grant      = st_q.req & daq_ready & ~st_q.load;
        st_d.req   = (st_q.req | req_set) & ~grant;
        st_d.load  = grant;
        st_d.clr   = st_q.load;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign load = st_q.load;
    assign clr  = st_q.clr;
endmodule

// File: rtl/hit_trigger_ctrl.sv
module hit_trigger_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic daq_ready,
    output logic lead_trig,
    output logic trail_trig,
    output logic blk_hit,
    output logic blk_pileup,
    output logic xfer_load,
    output logic pileup_clr
);
    logic rise, fall, req_set, load, clr, lead, trail;

    hit_edge_detect u_edge (
        .clk (clk), .rst (rst), .hit (hit),
        .rise(rise), .fall(fall)
    );

    hit_trig_state u_trig (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .load(load),
        .lead(lead), .trail(trail), .req_set(req_set)
    );

    hit_xfer_seq u_xfer (
        .clk(clk), .rst(rst), .req_set(req_set), .daq_ready(daq_ready),
        .load(load), .clr(clr)
    );

    assign lead_trig  = lead;
    assign blk_pileup = lead;
    assign trail_trig = trail;
    assign blk_hit    = trail;
    assign xfer_load  = load;
    assign pileup_clr = clr;
endmodule

// File: rtl/hit_trigger_ctrl_chk.sv
module hit_trigger_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic daq_ready,
    input logic lead_trig,
    input logic trail_trig,
    input logic xfer_load,
    input logic pileup_clr
);
    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!lead_trig && !trail_trig && !xfer_load && !pileup_clr)); // R1

    AST_LEAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (lead_trig && !xfer_load) |=> lead_trig); // R2

    AST_TRAIL_NEEDS_LEAD: assert property (@(posedge clk) disable iff (rst)
        $rose(trail_trig) |-> lead_trig); // R3

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        xfer_load |=> !xfer_load); // R4

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        xfer_load |=> (!lead_trig && !trail_trig)); // R5

    AST_LOAD_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_load) |-> ($past(daq_ready) && $past(trail_trig))); // R6

    AST_CLR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        xfer_load |=> pileup_clr); // R7

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pileup_clr |=> !pileup_clr); // R7
endmodule

bind hit_trigger_ctrl hit_trigger_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .daq_ready(daq_ready),
    .lead_trig(lead_trig), .trail_trig(trail_trig),
    .xfer_load(xfer_load), .pileup_clr(pileup_clr)
);

// File: tb/hit_trigger_ctrl_tb_top.sv
module hit_trigger_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst, hit, daq_ready;
    logic lead_trig, trail_trig, blk_hit, blk_pileup, xfer_load, pileup_clr;
    int   total = 0;
    int   bad   = 0;

    always #10 clk = ~clk;

    hit_trigger_ctrl dut_i (
        .clk(clk), .rst(rst), .hit(hit), .daq_ready(daq_ready),
        .lead_trig(lead_trig), .trail_trig(trail_trig),
        .blk_hit(blk_hit), .blk_pileup(blk_pileup),
        .xfer_load(xfer_load), .pileup_clr(pileup_clr)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // after a rising edge, sample 1 ns later
    task automatic tick();
        @(posedge clk); #1;
    endtask

    // drive at the falling edge
    task automatic drive(input logic h, input logic r);
        @(negedge clk);
        hit = h; daq_ready = r;
    endtask

    task automatic chk_all(input string req, input logic l, input logic t,
                           input logic ld, input logic c);
        chk(req, "lead_trig",  lead_trig,  l);
        chk(req, "blk_pileup", blk_pileup, l);
        chk(req, "trail_trig", trail_trig, t);
        chk(req, "blk_hit",    blk_hit,    t);
        chk(req, "xfer_load",  xfer_load,  ld);
        chk(req, "pileup_clr", pileup_clr, c);
    endtask

    task automatic t_reset();
        rst = 1'b1; hit = 1'b0; daq_ready = 1'b1;
        tick(); tick();
        chk_all("R1", 0, 0, 0, 0);
        drive(0, 1); rst = 1'b0;
        tick();
        chk_all("R1", 0, 0, 0, 0);
    endtask

    task automatic t_basic();
        drive(1, 1); tick();
        chk_all("R2", 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_all("R2", 1, 0, 0, 0);
        end
        drive(0, 1); tick();
        chk_all("R3", 1, 1, 0, 0);
        tick();
        chk_all("R4", 1, 1, 1, 0);
        tick();
        chk_all("R5", 0, 0, 0, 1);
        tick();
        chk_all("R7", 0, 0, 0, 0);
        tick();
        chk_all("R4", 0, 0, 0, 0);
    endtask

    task automatic t_stall();
        drive(1, 0); tick();
        chk_all("R2", 1, 0, 0, 0);
        drive(0, 0); tick();
        chk_all("R3", 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk_all("R6", 1, 1, 0, 0);
        end
        drive(0, 1); tick();
        chk_all("R6", 1, 1, 1, 0);
        tick();
        chk_all("R6", 0, 0, 0, 1);
        tick();
        chk_all("R7", 0, 0, 0, 0);
    endtask

    task automatic t_late_hit();
        drive(1, 0); tick();
        chk_all("R2", 1, 0, 0, 0);
        drive(0, 0); tick();
        chk_all("R3", 1, 1, 0, 0);
        drive(1, 0); tick();               // second rise while pending
        chk_all("R8", 1, 1, 0, 0);
        drive(1, 1); tick();
        chk_all("R8", 1, 1, 1, 0);
        tick();                            // clear while hit still high
        chk_all("R8", 0, 0, 0, 1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_all("R8", 0, 0, 0, 0);
        end
        drive(0, 1);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk_all("R8", 0, 0, 0, 0);
        end
    endtask

    task automatic t_reset_mid();
        drive(1, 0); tick();
        drive(0, 0); tick();
        chk_all("R3", 1, 1, 0, 0);
        @(negedge clk); rst = 1'b1;
        tick();
        chk_all("R1", 0, 0, 0, 0);
        @(negedge clk); rst = 1'b0; daq_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_all("R1", 0, 0, 0, 0);
        end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_stall();
        t_late_hit();
        t_reset_mid();
        t_basic();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule